// File: doc/BRIEF.md
# Serial systematic LDPC encoder with parity accumulator

The encoder turns a serial stream of information bits into one systematic low-density parity-check codeword. The information bits go straight to the output as they arrive. Meanwhile each accepted bit flips four check positions in a parity register. When the last information bit has been accepted, the register is streamed out through a running XOR (a 1/(1+D) accumulator). This gives the parity of a code whose check matrix is a sparse information part followed by a dual-diagonal part, so no dense generator matrix is needed. At default size a codeword holds up to 1600 information bits and always 400 parity bits.

A codeword begins with a start pulse that carries the payload length N, from 1 up to the full information size. Payloads shorter than a full block behave as if the missing positions were zeros at the end of the block. Those zeros cost no transfers and no clock cycles, and the full set of parity bits is still sent. A long payload is sent as a series of codewords, and the next codeword starts only after the previous one ends. The check positions for the information bit with index k are rows (k mod P) + j·P/4, reduced mod P, for j = 0..3, where P is the number of parity bits. If the information size is a multiple of P, every row collects the same number of connections: 16 at default size.

Top module: `ldpc_acc_encoder`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, out_valid_o and in_ready_o are 0.
- R2: After an accepted start, exactly N information bits pass to the output unchanged and in order. out_valid_o follows in_valid_i, in_ready_o follows out_ready_i, and a bit is consumed only when both are high.
- R3: After the information bits come exactly P parity bits, lowest index first. Intermediate bit t_i is the XOR of every sent information bit whose four check rows (k mod P + j·P/4) mod P, j = 0..3, include i. Parity bit p_i = t_i XOR p_(i-1), with p_(-1) = 0.
- R4: out_last_o is 1 only together with out_valid_o on the final parity bit of a codeword.
- R5: The missing positions of a shortened codeword are never sent. The first parity bit is valid in the cycle right after the last information bit is accepted. in_ready_o stays 0 while parity is being sent.
- R6: A start pulse that arrives while a codeword is in progress is ignored. The current codeword is not changed.
- R7: A start pulse with N = 0 or N larger than the information size is ignored, and the block stays idle.
- R8: Parity state is cleared for each codeword, so back-to-back codewords are independent. After the final parity bit the block is idle, with no output and no input ready.
- R9: While a parity bit is offered and out_ready_i is 0, out_valid_o, out_bit_o and out_last_o keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a codeword (taken only when idle) |
| len_i | input | $clog2(INFO_BITS+1) | Information bits in this codeword, N |
| in_bit_i | input | 1 | Serial information bit |
| in_valid_i | input | 1 | in_bit_i is valid |
| in_ready_o | output | 1 | Encoder takes in_bit_i |
| out_bit_o | output | 1 | Serial coded bit |
| out_valid_o | output | 1 | out_bit_o is valid |
| out_ready_i | input | 1 | Downstream takes out_bit_o |
| out_last_o | output | 1 | Final parity bit of the codeword |

## Verification
A wrong row address or a missed toggle stays hidden until the parity phase. It then shows as a wrong parity bit at the first affected index, and every later bit is also inverted because the running XOR carries the error forward. A miscounted length or position counter shows at once as a parity phase that starts a cycle early or late, or as a last flag on the wrong bit. Parity state left over from the previous codeword corrupts the parity of the next codeword. Sweeping every length of a small configuration, with and without backpressure, exposes each of these within one codeword.

// File: rtl/ldpc_acc_pkg.sv
package ldpc_acc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_PAR} enc_state_e;
  // sparse-part edges per information bit
  localparam int unsigned EDGES_PER_BIT = 4;
endpackage

// File: rtl/ldpc_row_gen.sv
module ldpc_row_gen #(
  parameter int unsigned PAR_BITS = 400,
  parameter int unsigned LANES    = 4,
  parameter int unsigned IDX_W    = $clog2(PAR_BITS)
) (
  input  logic [IDX_W-1:0]            res_i,
  output logic [LANES-1:0][IDX_W-1:0] rows_o
);
  localparam int unsigned STEP = PAR_BITS / LANES;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam logic [IDX_W:0] OFS = (IDX_W+1)'(l * STEP);
    logic [IDX_W:0] sum;
    logic [IDX_W:0] wrap;
    assign sum  = {1'b0, res_i} + OFS;
    assign wrap = sum - (IDX_W+1)'(PAR_BITS);
    assign rows_o[l] = (sum >= (IDX_W+1)'(PAR_BITS)) ? wrap[IDX_W-1:0] : sum[IDX_W-1:0];
  end
endmodule

// File: rtl/ldpc_parity_acc.sv
module ldpc_parity_acc #(
  parameter int unsigned PAR_BITS = 400,
  parameter int unsigned LANES    = 4,
  parameter int unsigned IDX_W    = $clog2(PAR_BITS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        clr_i,
  input  logic                        tog_en_i,
  input  logic                        tog_bit_i,
  input  logic [LANES-1:0][IDX_W-1:0] rows_i,
  input  logic                        shift_en_i,
  output logic                        par_bit_o
);
  logic [PAR_BITS-1:0] chk_q;
  logic [PAR_BITS-1:0] tog_mask;
  logic                acc_q;

  always_comb begin
    tog_mask = '0;
    for (int l = 0; l < LANES; l++) tog_mask[rows_i[l]] = 1'b1;
  end

  // 1/(1+D) applied while streaming: no separate pass
  assign par_bit_o = acc_q ^ chk_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_q <= '0;
      acc_q <= 1'b0;
    end else if (clr_i) begin
      chk_q <= '0;
      acc_q <= 1'b0;
    end else if (tog_en_i) begin
      if (tog_bit_i) chk_q <= chk_q ^ tog_mask;
    end else if (shift_en_i) begin
      chk_q <= {1'b0, chk_q[PAR_BITS-1:1]};
      acc_q <= par_bit_o;
    end
  end
endmodule

// File: rtl/ldpc_enc_ctrl.sv
module ldpc_enc_ctrl
  import ldpc_acc_pkg::*;
#(
  parameter int unsigned INFO_BITS = 1600,
  parameter int unsigned PAR_BITS  = 400,
  parameter int unsigned LEN_W     = $clog2(INFO_BITS + 1),
  parameter int unsigned IDX_W     = $clog2(PAR_BITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             in_valid_i,
  input  logic             out_ready_i,
  output enc_state_e       state_o,
  output logic             clr_o,
  output logic             tog_en_o,
  output logic             shift_en_o,
  output logic [IDX_W-1:0] res_o,
  output logic             last_o
);
  enc_state_e       state_q;
  logic [LEN_W-1:0] len_q, cnt_q;
  logic [IDX_W-1:0] res_q, pidx_q;
  logic             len_ok, accept, data_hs, par_hs;

  assign len_ok  = (len_i != '0) && (len_i <= LEN_W'(INFO_BITS));
  assign accept  = (state_q == ST_IDLE) && start_i && len_ok;
  assign data_hs = (state_q == ST_DATA) && in_valid_i && out_ready_i;
  assign par_hs  = (state_q == ST_PAR) && out_ready_i;
  assign last_o  = (state_q == ST_PAR) && (pidx_q == IDX_W'(PAR_BITS - 1));

  assign state_o    = state_q;
  assign clr_o      = accept;
  assign tog_en_o   = data_hs;
  assign shift_en_o = par_hs;
  assign res_o      = res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      len_q   <= '0;
      cnt_q   <= '0;
      res_q   <= '0;
      pidx_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          len_q   <= len_i;
          cnt_q   <= '0;
          res_q   <= '0;
          state_q <= ST_DATA;
        end
        ST_DATA: if (data_hs) begin
          cnt_q <= cnt_q + LEN_W'(1);
          res_q <= (res_q == IDX_W'(PAR_BITS - 1)) ? '0 : res_q + IDX_W'(1);
          // pad positions are skipped: go straight to parity
          if (cnt_q == len_q - LEN_W'(1)) begin
            pidx_q  <= '0;
            state_q <= ST_PAR;
          end
        end
        ST_PAR: if (par_hs) begin
          pidx_q <= pidx_q + IDX_W'(1);
          if (last_o) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ldpc_acc_encoder.sv
module ldpc_acc_encoder
  import ldpc_acc_pkg::*;
#(
  parameter int unsigned INFO_BITS = 1600,
  parameter int unsigned PAR_BITS  = 400
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           start_i,
  input  logic [$clog2(INFO_BITS+1)-1:0] len_i,
  input  logic                           in_bit_i,
  input  logic                           in_valid_i,
  output logic                           in_ready_o,
  output logic                           out_bit_o,
  output logic                           out_valid_o,
  input  logic                           out_ready_i,
  output logic                           out_last_o
);
  localparam int unsigned LEN_W = $clog2(INFO_BITS + 1);
  localparam int unsigned IDX_W = $clog2(PAR_BITS);
  localparam int unsigned LANES = EDGES_PER_BIT;

  enc_state_e                  state;
  logic                        clr, tog_en, shift_en, last, par_bit;
  logic [IDX_W-1:0]            res;
  logic [LANES-1:0][IDX_W-1:0] rows;
  logic                        data_phase, par_phase;

  ldpc_enc_ctrl #(
    .INFO_BITS(INFO_BITS), .PAR_BITS(PAR_BITS), .LEN_W(LEN_W), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk_i, .rst_ni, .start_i, .len_i, .in_valid_i, .out_ready_i,
    .state_o(state), .clr_o(clr), .tog_en_o(tog_en), .shift_en_o(shift_en),
    .res_o(res), .last_o(last)
  );

  ldpc_row_gen #(.PAR_BITS(PAR_BITS), .LANES(LANES), .IDX_W(IDX_W)) u_rows (
    .res_i(res), .rows_o(rows)
  );

  ldpc_parity_acc #(.PAR_BITS(PAR_BITS), .LANES(LANES), .IDX_W(IDX_W)) u_par (
    .clk_i, .rst_ni, .clr_i(clr), .tog_en_i(tog_en), .tog_bit_i(in_bit_i),
    .rows_i(rows), .shift_en_i(shift_en), .par_bit_o(par_bit)
  );

  assign data_phase  = (state == ST_DATA);
  assign par_phase   = (state == ST_PAR);
  assign in_ready_o  = data_phase && out_ready_i;
  assign out_valid_o = data_phase ? in_valid_i : par_phase;
  assign out_bit_o   = data_phase ? in_bit_i : (par_phase && par_bit);
  assign out_last_o  = last;
endmodule

// File: rtl/ldpc_acc_encoder_chk.sv
module ldpc_acc_encoder_chk #(
  parameter int unsigned PAR_BITS = 400
) (
  input logic clk_i,
  input logic rst_ni,
  input logic in_ready_o,
  input logic out_bit_o,
  input logic out_valid_o,
  input logic out_ready_i,
  input logic out_last_o,
  input logic par_phase
);
  localparam int unsigned CW = $clog2(PAR_BITS + 1);
  logic [CW-1:0] par_cnt_q;
  logic          par_hs;

  assign par_hs = par_phase && out_valid_o && out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  par_cnt_q <= '0;
    else if (par_hs && out_last_o) par_cnt_q <= '0;
    else if (par_hs)               par_cnt_q <= par_cnt_q + CW'(1);
  end

  p_ready_follows_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> out_ready_i);

  p_par_count_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_hs && out_last_o) |-> (par_cnt_q == CW'(PAR_BITS - 1)));

  p_last_in_par_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |-> (out_valid_o && par_phase));

  p_no_input_in_par_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_phase |-> !in_ready_o);

  p_idle_after_last_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_hs && out_last_o) |=> (!out_valid_o && !in_ready_o));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_phase && out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_bit_o) && $stable(out_last_o)));
endmodule

bind ldpc_acc_encoder ldpc_acc_encoder_chk #(.PAR_BITS(PAR_BITS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_ready_o(in_ready_o), .out_bit_o(out_bit_o),
  .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_last_o(out_last_o),
  .par_phase(par_phase)
);

// File: tb/ldpc_acc_encoder_bench.sv
module ldpc_acc_encoder_bench;
  localparam int K  = 16;
  localparam int M  = 8;
  localparam int LW = $clog2(K + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, in_bit_i = 1'b0, in_valid_i = 1'b0, out_ready_i = 1'b0;
  logic [LW-1:0] len_i = '0;
  logic in_ready_o, out_bit_o, out_valid_o, out_last_o;
  int checks = 0, errors = 0, cycles = 0;

  always #5 clk = ~clk;

  ldpc_acc_encoder #(.INFO_BITS(K), .PAR_BITS(M)) u_ldpc_acc_encoder (
    .clk_i(clk), .rst_ni(rst_n), .start_i, .len_i, .in_bit_i, .in_valid_i,
    .in_ready_o, .out_bit_o, .out_valid_o, .out_ready_i, .out_last_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected 0", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run_cw(input int n, input int seed, input bit bp, input bit inject);
    logic [K-1:0] u;
    logic [M-1:0] t, pexp;
    logic acc;
    int di, oi, cyc, bad_d, bad_p, bad_l, pend;
    bit done;
    for (int k = 0; k < K; k++) u[k] = 1'(((k * 13 + seed * 7 + k * k * seed) >> 1) & 1);
    t = '0;
    for (int k = 0; k < n; k++)
      for (int j = 0; j < 4; j++) t[(k % M + j * (M / 4)) % M] ^= u[k];
    acc = 1'b0;
    for (int i = 0; i < M; i++) begin acc ^= t[i]; pexp[i] = acc; end

    @(negedge clk);
    start_i = 1'b1; len_i = LW'(n);
    @(negedge clk);
    start_i = 1'b0;
    di = 0; oi = 0; cyc = 0; bad_d = 0; bad_p = 0; bad_l = 0; pend = 0; done = 0;
    while (!done && cyc < 400) begin
      in_valid_i  = (di < n);
      in_bit_i    = (di < n) ? u[di] : 1'b0;
      out_ready_i = bp ? (cyc % 3 != 1) : 1'b1;
      start_i     = inject && (di == 2);
      len_i       = inject ? LW'(1) : LW'(n);
      #1;
      if (pend == 1) begin
        chk(out_valid_o && !in_ready_o, "R5 parity next cycle", int'(out_valid_o), 1);
        pend = 2;
      end
      if (out_valid_o && out_ready_i) begin
        if (oi < n) begin
          if (out_bit_o !== u[oi]) bad_d++;
        end else if (oi < n + M) begin
          if (out_bit_o !== pexp[oi - n]) bad_p++;
        end
        if (out_last_o !== (oi == n + M - 1)) bad_l++;
        if (out_last_o) done = 1;
        oi++;
      end
      if (in_valid_i && in_ready_o) begin
        di++;
        if (di == n) pend = 1;
      end
      cyc++;
      @(negedge clk);
    end
    start_i = 1'b0; in_valid_i = 1'b1; out_ready_i = 1'b1;
    #1;
    chk(bad_d == 0, "R2 data passthrough", bad_d, 0);
    chk(oi == n + M, "R3 codeword length", oi, n + M);
    chk(bad_p == 0, "R3 R8 parity values", bad_p, 0);
    chk(bad_l == 0, "R4 last flag", bad_l, 0);
    chk(!out_valid_o && !in_ready_o, "R8 idle after last", int'(out_valid_o), 0);
    if (inject) chk(bad_p == 0 && oi == n + M, "R6 start while busy ignored", oi, n + M);
    in_valid_i = 1'b0;
  endtask

  task automatic bad_len(input int n);
    @(negedge clk);
    start_i = 1'b1; len_i = LW'(n);
    @(negedge clk);
    start_i = 1'b0; in_valid_i = 1'b1; out_ready_i = 1'b1;
    #1;
    chk(!in_ready_o && !out_valid_o, "R7 invalid length ignored", int'(in_ready_o), 0);
    @(negedge clk);
    in_valid_i = 1'b0;
  endtask

  initial begin
    in_valid_i = 1'b1; out_ready_i = 1'b1;
    #12;
    chk(!out_valid_o && !in_ready_o, "R1 reset state", int'(out_valid_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!out_valid_o && !in_ready_o, "R1 after release", int'(in_ready_o), 0);
    in_valid_i = 1'b0;
    bad_len(0);
    bad_len(K + 1);
    for (int n = 1; n <= K; n++) begin
      run_cw(n, n, 1'b0, 1'b0);
      run_cw(n, n + 31, 1'b1, 1'b0);
    end
    run_cw(K, 5, 1'b1, 1'b1);
    run_cw(7, 9, 1'b0, 1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule